// File: doc/BRIEF.md
# Presettable Decade/Binary Up-Down Counter

A four-bit synchronous counter that counts either through the ten BCD digits 0 to 9 or through all sixteen binary codes 0 to 15. A parameter selects the mode when the block is built. On any rising clock edge the counter does one of four things: it clears, it loads a four-bit preset, it steps up or down by one, or it holds its value. A direction input sets the counting direction.

There are two active-low count enables. Both must be low for the counter to step. Only the chain enable gates the active-low terminal-count output. That output depends only on the present count, the direction input and the chain enable, so it can drive the chain enable of the next stage. Stages wired this way form a multi-digit counter with carry lookahead, and a single shared enable then moves the whole chain.

In decade mode a preset or an unknown start-up value can leave the counter in one of the unused codes 10 to 15. The next-state logic returns the counter to the legal digits within two counts.

Top module: `updn_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0. This takes priority over every other input.
- R2: When `rst` is low and `load_n` is low at a rising edge, `count` takes the value of `preset`. The enables and `up` have no effect in that cycle.
- R3: When `load_n` is high and either `ena_par_n` or `ena_chain_n` is high at a rising edge, `count` keeps its value.
- R4: When `load_n`, `ena_par_n` and `ena_chain_n` are all active for counting, `count` steps up by one when `up` is 1 and down by one when `up` is 0. This applies to legal codes away from the wrap point.
- R5: Counting up wraps from the top code to 0. Counting down wraps from 0 to the top code. The top code is 9 when `DECADE`=1 and 15 when `DECADE`=0.
- R6: `tc_n` is 0 only when `ena_chain_n` is 0 and the counter is at its end state; otherwise `tc_n` is 1. The end state is `count`=0 when `up`=0 and the top code when `up`=1. `tc_n` is combinational and follows its inputs in the same cycle.
- R7: `tc_n` does not depend on `ena_par_n`.
- R8: With `DECADE`=1, a count up from 10, 12 or 14 goes to 11, 13 or 15. A count up from 11, 13 or 15 goes to 0. A count down from any code between 10 and 15 goes to 9. Any illegal code therefore reaches 0 to 9 within two counts.
- R9: With `DECADE`=1 and `up`=1, the end state is decoded from bits 0 and 3 only. `tc_n` therefore also goes low in codes 11, 13 and 15 when `ena_chain_n` is 0.
- R10: Two stages can be cascaded. Both stages share `ena_par_n`, and the low stage's `tc_n` drives the high stage's `ena_chain_n`. The pair then counts as one two-digit value in both directions and wraps in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous clear, active high |
| load_n | input | 1 | Preset load, active low |
| preset | input | 4 | Value captured on a load |
| ena_par_n | input | 1 | Count enable that does not affect `tc_n`, active low |
| ena_chain_n | input | 1 | Count enable that also gates `tc_n`, active low |
| up | input | 1 | 1 counts up, 0 counts down |
| count | output | 4 | Present count |
| tc_n | output | 1 | Terminal count, active low |

## Verification
Every change of `count` is due at the first rising edge after the inputs that cause it are applied. `tc_n` is due in the same cycle as the inputs that set it, because it is combinational. The bench drives all inputs on the falling edge and samples both outputs one nanosecond later. It compares them against a model state that it advances only at the following rising edge. In a two-stage chain the high stage's enable is the low stage's `tc_n`. The model therefore computes the low stage's terminal count first and uses it in the same cycle to predict the high stage.

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter bit DECADE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_n,
  input  logic [3:0] preset,
  input  logic       ena_par_n,
  input  logic       ena_chain_n,
  input  logic       up,
  output logic [3:0] count,
  output logic       tc_n
);
  localparam logic [3:0] TOP = DECADE ? 4'd9 : 4'd15;

  logic       run;
  logic       at_end;
  logic [3:0] inc, dec, nxt;

  assign run = load_n & ~ena_par_n & ~ena_chain_n;

  always_comb begin
    inc = count + 4'd1;
    dec = count - 4'd1;
    if (DECADE) begin
      if (count == 4'd9 || (count > 4'd9 && count[0])) inc = 4'd0;
      if (count == 4'd0 || count > 4'd9) dec = 4'd9;
    end
  end

  assign nxt = up ? inc : dec;

  always_comb begin
    if (!up)         at_end = (count == 4'd0);
    else if (DECADE) at_end = count[0] & count[3];
    else             at_end = &count;
  end

  assign tc_n = ~(at_end & ~ena_chain_n);

  always_ff @(posedge clk) begin
    if (rst)          count <= 4'd0;
    else if (!load_n) count <= preset;
    else if (run)     count <= nxt;
  end

  a_r1_clear: assert property (@(posedge clk) rst |=> count == 4'd0);

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> count == $past(preset));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    load_n && (ena_par_n || ena_chain_n) |=> $stable(count));

  a_r4_step_up: assert property (@(posedge clk) disable iff (rst)
    run && up && count < TOP |=> count == $past(count) + 4'd1);

  a_r5_wrap_up: assert property (@(posedge clk) disable iff (rst)
    run && up && count == TOP |=> count == 4'd0);

  a_r5_wrap_down: assert property (@(posedge clk) disable iff (rst)
    run && !up && count == 4'd0 |=> count == TOP);

  a_r6_tc_gated: assert property (@(posedge clk) disable iff (rst)
    ena_chain_n |-> tc_n);

  a_r8_illegal_down: assert property (@(posedge clk) disable iff (rst)
    DECADE && run && !up && count > 4'd9 |=> count == 4'd9);

  a_r8_illegal_up_odd: assert property (@(posedge clk) disable iff (rst)
    DECADE && run && up && count > 4'd9 && count[0] |=> count == 4'd0);
endmodule

// File: tb/test_updn_counter.sv
`timescale 1ns/1ps
module test_updn_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, load_n = 1'b1, par_n = 1'b1, chain_n = 1'b1, up = 1'b1;
  logic [3:0] pre_lo = 4'd0, pre_hi = 4'd0;
  logic [3:0] q [4];
  logic       tc [4];

  updn_counter #(.DECADE(1'b1)) i_updn_counter (
    .clk(clk), .rst(rst), .load_n(load_n), .preset(pre_lo), .ena_par_n(par_n),
    .ena_chain_n(chain_n), .up(up), .count(q[0]), .tc_n(tc[0]));
  updn_counter #(.DECADE(1'b1)) i_updn_counter_hi (
    .clk(clk), .rst(rst), .load_n(load_n), .preset(pre_hi), .ena_par_n(par_n),
    .ena_chain_n(tc[0]), .up(up), .count(q[1]), .tc_n(tc[1]));
  updn_counter #(.DECADE(1'b0)) i_updn_counter_bin (
    .clk(clk), .rst(rst), .load_n(load_n), .preset(pre_lo), .ena_par_n(par_n),
    .ena_chain_n(chain_n), .up(up), .count(q[2]), .tc_n(tc[2]));
  updn_counter #(.DECADE(1'b0)) i_updn_counter_bin_hi (
    .clk(clk), .rst(rst), .load_n(load_n), .preset(pre_hi), .ena_par_n(par_n),
    .ena_chain_n(tc[2]), .up(up), .count(q[3]), .tc_n(tc[3]));

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [3:0] m [4];
  string tag [4];

  function automatic logic [3:0] step_of(bit dec, logic [3:0] v, bit u);
    if (u) begin
      if (dec && v == 4'd9) return 4'd0;
      if (dec && v > 4'd9) return v[0] ? 4'd0 : v + 4'd1;
      return v + 4'd1;
    end
    if (dec && (v == 4'd0 || v > 4'd9)) return 4'd9;
    return v - 4'd1;
  endfunction

  function automatic bit end_of(bit dec, logic [3:0] v, bit u);
    if (!u) return v == 4'd0;
    if (dec) return v == 4'd9 || v == 4'd11 || v == 4'd13 || v == 4'd15;
    return v == 4'd15;
  endfunction

  task automatic check(string r, int exp_v, int act_v, string what);
    checks++;
    if (exp_v != act_v) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act_v, exp_v);
    end
  endtask

  task automatic cyc(bit r, bit ld, bit pn, bit cn, bit u, logic [3:0] plo, logic [3:0] phi);
    bit chain [4];
    bit etc [4];
    @(negedge clk);
    rst = r; load_n = ld; par_n = pn; chain_n = cn; up = u; pre_lo = plo; pre_hi = phi;
    #1;
    for (int i = 0; i < 4; i++) begin
      bit dec = (i < 2);
      chain[i] = (i % 2 == 0) ? cn : etc[i-1];
      etc[i] = !(!chain[i] && end_of(dec, m[i], u));
      check(tag[i], m[i], q[i], $sformatf("count[%0d]", i));
      if (dec && u && m[i] > 4'd9 && m[i][0] && !chain[i])
        check("R9", etc[i], tc[i], $sformatf("tc_n[%0d]", i));
      else if (pn)
        check("R7", etc[i], tc[i], $sformatf("tc_n[%0d]", i));
      else
        check("R6", etc[i], tc[i], $sformatf("tc_n[%0d]", i));
    end
    for (int i = 0; i < 4; i++) begin
      bit dec = (i < 2);
      if (r) begin m[i] = 4'd0; tag[i] = "R1"; end
      else if (!ld) begin m[i] = (i % 2 == 0) ? plo : phi; tag[i] = "R2"; end
      else if (pn || chain[i]) tag[i] = "R3";
      else begin
        if (i % 2 == 1) tag[i] = "R10";
        else if (dec && m[i] > 4'd9) tag[i] = "R8";
        else if ((u && end_of(dec, m[i], 1'b1)) || (!u && m[i] == 4'd0)) tag[i] = "R5";
        else tag[i] = "R4";
        m[i] = step_of(dec, m[i], u);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin m[i] = 4'd0; tag[i] = "R1"; end
    @(posedge clk);
    cyc(1, 1, 0, 0, 1, 4'd5, 4'd5);
    cyc(1, 0, 0, 0, 1, 4'd7, 4'd3);
    cyc(0, 1, 0, 0, 1, 0, 0);
    // up through two-digit wrap, then down
    for (int k = 0; k < 270; k++) cyc(0, 1, 0, 0, 1, 0, 0);
    for (int k = 0; k < 270; k++) cyc(0, 1, 0, 0, 0, 0, 0);
    // holds by either enable, TC with parallel enable high
    cyc(0, 0, 0, 0, 1, 4'd9, 4'd15);
    cyc(0, 1, 1, 0, 1, 0, 0);
    cyc(0, 1, 0, 1, 1, 0, 0);
    cyc(0, 1, 1, 1, 0, 0, 0);
    // load priority over enables and direction
    cyc(0, 0, 1, 1, 0, 4'd3, 4'd12);
    // illegal decade codes in both directions
    for (int v = 10; v < 16; v++) begin
      cyc(0, 0, 0, 0, 1, v[3:0], v[3:0]);
      cyc(0, 1, 0, 0, 1, 0, 0);
      cyc(0, 1, 0, 0, 1, 0, 0);
      cyc(0, 1, 0, 0, 1, 0, 0);
      cyc(0, 0, 0, 0, 0, v[3:0], v[3:0]);
      cyc(0, 1, 0, 0, 0, 0, 0);
      cyc(0, 1, 0, 0, 0, 0, 0);
    end
    // random mix
    for (int k = 0; k < 4000; k++) begin
      bit r  = ($urandom % 97) == 0;
      bit ld = ($urandom % 13) != 0;
      bit pn = ($urandom % 5) == 0;
      bit cn = ($urandom % 6) == 0;
      bit u  = ($urandom % 40 < 20) ? (k / 300) % 2 == 0 : $urandom % 2 == 0;
      cyc(r, ld, pn, cn, u, 4'($urandom), 4'($urandom));
    end
    cyc(0, 1, 1, 1, 1, 0, 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule